// File: doc/BRIEF.md
# Posit Multiply-Accumulate Unit

This block multiplies two posit operands on every cycle that carries a valid flag and adds the product into a running sum. It returns that sum as a posit of the same format. Each operand is first unpacked into sign, scale and significand. The product is then added into a signed fixed-point accumulator whose binary point and width cover every product the format can produce, so the sum itself never loses bits. The sum is packed back into a posit only at the output, by truncation toward zero. Sums outside the representable range are clamped.

The word size `N` and exponent field size `ES` are parameters. The supported formats are (8,1), (8,2), (16,1) and (16,2), with `ES` of 1 or 2. The pipeline is three registers deep: unpack, multiply-add, pack. A new pair may enter on every cycle. A caller starts a fresh dot product by raising `clear_i` together with the first operand pair. Every later valid pair adds into the same sum.

Top module: `posit_mac`

## Requirements
- R1: `valid_o` rises exactly three rising edges after the edge that samples `valid_i` high, and stays low when no valid pair is in flight.
- R2: An operand code is read as a posit: all zeros is 0, and a 1 followed by all zeros is not-a-real (NaR). A negative code is the two's complement of its magnitude code. A magnitude code has a run of m equal regime bits after the sign, followed by an opposite bit, then `ES` exponent bits (missing bits read as 0), then the fraction. Its value is 2^(k·2^ES + e)·(1.f), where k = m−1 for a run of ones and k = −m for a run of zeros.
- R3: A valid pair with `clear_i` high replaces the sum with its own product.
- R4: A valid pair with `clear_i` low adds its product into the sum with no loss of precision.
- R5: `result_o` is the posit of largest magnitude that does not exceed the magnitude of the sum, with the sign of the sum (truncation toward zero).
- R6: A sum above maxpos in magnitude (code 0 followed by all ones) gives ±maxpos. A nonzero sum below minpos (code 0…01) gives ±minpos.
- R7: A zero operand contributes an exact zero product. A sum of exactly zero gives code all zeros.
- R8: A NaR operand makes the result NaR for that pair and for all later pairs, until a pair with `clear_i` high and no NaR operand.
- R9: Cycles with `valid_i` low leave the sum unchanged, whatever `clear_i`, `a_i` and `b_i` carry. `result_o` holds its value while `valid_o` is low.
- R10: While `rst_ni` is low, `valid_o` is 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair valid this cycle |
| clear_i | input | 1 | Start a new sum with this pair (qualified by valid_i) |
| a_i | input | N | First posit operand |
| b_i | input | N | Second posit operand |
| valid_o | output | 1 | Result valid |
| result_o | output | N | Running sum as a posit |

## Verification
The bench drives every nonzero, non-NaR code times one with a clear, so each result must come back as the same code. A decoder that miscounts the regime run or misplaces the exponent bits shows up as a wrong code on some of these rows. Products just above and below representable values, with both signs, catch a packer that rounds to nearest or rounds away from zero on negatives. Maxpos² and minpos² catch wrap-around in place of clamping, and minpos² also catches a flush to zero. A sum that cancels to exactly zero, a NaR followed by ordinary pairs, and a cleared idle cycle between valid pairs expose a non-sticky NaR flag, a zero sum packed as minpos, and a clear applied without its valid. Random streams with gaps also confirm that the latency does not drift under back-pressure-free bursts.

// File: rtl/posit_mac_pkg.sv
package posit_mac_pkg;

  typedef enum logic [1:0] {
    PC_ZERO = 2'd0,
    PC_REAL = 2'd1,
    PC_NAR  = 2'd2
  } pclass_e;

  // largest |scale| of a format: maxpos = 2^max_scale
  function automatic int max_scale(int n, int es);
    return (n - 2) << es;
  endfunction

  // fraction bits kept by the decoder
  function automatic int frac_bits(int n, int es);
    return n - 3 - es;
  endfunction

  // signed scale field, wide enough for the sum of two scales plus offset
  function automatic int scale_width(int n, int es);
    return $clog2(4 * max_scale(n, es) + 1) + 2;
  endfunction

  // fixed-point accumulator: lsb = minpos^2, sign bit, growth guard bits
  function automatic int acc_width(int n, int es, int gb);
    return 4 * max_scale(n, es) + 2 + gb;
  endfunction

endpackage

// File: rtl/posit_decoder.sv
module posit_decoder
  import posit_mac_pkg::*;
#(
  parameter int N   = 8,
  parameter int ES  = 1,
  parameter int SCW = 8,
  parameter int FB  = 4
) (
  input  logic [N-1:0]          p_i,
  output pclass_e               cls_o,
  output logic                  sign_o,
  output logic signed [SCW-1:0] scale_o,
  output logic [FB:0]           sig_o
);

  logic [N-1:0] mag;
  logic [N-2:0] rem;
  logic         r0;
  logic         stop;
  int           run;
  int           k;

  always_comb begin
    mag  = p_i[N-1] ? (~p_i + N'(1)) : p_i;
    r0   = mag[N-2];
    run  = 0;
    stop = 1'b0;
    for (int i = N - 2; i >= 0; i--) begin
      if (!stop && (mag[i] == r0)) run++;
      else stop = 1'b1;
    end
    rem     = mag[N-2:0] << (run + 1);  // drop regime and terminator
    k       = r0 ? (run - 1) : -run;
    scale_o = SCW'(k * (2 ** ES) + int'(rem[N-2 -: ES]));
    sig_o   = {1'b1, rem[N-2-ES -: FB]};
    sign_o  = p_i[N-1];
    if (p_i == '0)                         cls_o = PC_ZERO;
    else if (p_i == {1'b1, {(N-1){1'b0}}}) cls_o = PC_NAR;
    else                                   cls_o = PC_REAL;
  end

endmodule

// File: rtl/posit_mac_core.sv
module posit_mac_core
  import posit_mac_pkg::*;
#(
  parameter int N   = 8,
  parameter int ES  = 1,
  parameter int GB  = 8,
  parameter int SCW = 8,
  parameter int FB  = 4,
  parameter int AW  = 58
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic                  clear_i,
  input  pclass_e               cls_a_i,
  input  logic                  sign_a_i,
  input  logic signed [SCW-1:0] scale_a_i,
  input  logic [FB:0]           sig_a_i,
  input  pclass_e               cls_b_i,
  input  logic                  sign_b_i,
  input  logic signed [SCW-1:0] scale_b_i,
  input  logic [FB:0]           sig_b_i,
  output logic                  valid_o,
  output logic                  nar_o,
  output logic signed [AW-1:0]  acc_o
);

  localparam int SMAX = max_scale(N, ES);
  localparam int PW   = 2 * (FB + 1);
  localparam int EW   = AW + 2 * FB;

  logic [PW-1:0]         prod;
  logic signed [SCW-1:0] shamt;
  logic [EW-1:0]         ext;
  logic [AW-1:0]         tmag;
  logic signed [AW-1:0]  term;
  logic                  real_pair;
  logic                  nar_in;

  always_comb begin
    prod      = PW'(sig_a_i) * PW'(sig_b_i);
    // product lsb weight 2^(sa+sb-2FB); accumulator lsb weight 2^(-2*SMAX)
    shamt     = scale_a_i + scale_b_i + SCW'(2 * SMAX);
    ext       = EW'(prod) << shamt;
    tmag      = ext[EW-1 -: AW];
    real_pair = (cls_a_i == PC_REAL) && (cls_b_i == PC_REAL);
    nar_in    = (cls_a_i == PC_NAR) || (cls_b_i == PC_NAR);
    if (!real_pair)                term = '0;
    else if (sign_a_i ^ sign_b_i)  term = -$signed(tmag);
    else                           term = $signed(tmag);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      nar_o   <= 1'b0;
      acc_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        acc_o <= clear_i ? term : (acc_o + term);
        nar_o <= clear_i ? nar_in : (nar_o | nar_in);
      end
    end
  end

endmodule

// File: rtl/posit_encoder.sv
module posit_encoder
  import posit_mac_pkg::*;
#(
  parameter int N  = 8,
  parameter int ES = 1,
  parameter int AW = 58
) (
  input  logic signed [AW-1:0] acc_i,
  input  logic                 nar_i,
  output logic [N-1:0]         posit_o
);

  localparam int SMAX = max_scale(N, ES);
  localparam int TW   = N + ES + AW;

  logic          neg;
  logic [AW-1:0] mag;
  logic [AW-1:0] frac;
  logic [TW-1:0] vec;
  logic [N-2:0]  body;
  int            lead;
  int            s;
  int            k;
  int            e;
  int            rl;

  always_comb begin
    neg  = acc_i[AW-1];
    mag  = neg ? -acc_i : acc_i;
    lead = 0;
    for (int i = 0; i < AW; i++) begin
      if (mag[i]) lead = i;
    end
    s    = lead - 2 * SMAX;
    k    = s >>> ES;
    e    = s - k * (2 ** ES);
    frac = mag << (AW - lead);           // bits below the leading one
    rl   = (k >= 0) ? (k + 2) : (1 - k); // regime run plus terminator
    vec  = {ES'(e), frac, {N{1'b0}}} >> rl;
    if (k >= 0) vec = vec | ~({TW{1'b1}} >> (rl - 1));
    else        vec = vec | (TW'(1) << (TW - rl));
    body = vec[TW-1 -: N-1];             // truncation toward zero
    if (s > SMAX)       body = '1;
    else if (s < -SMAX) body = (N-1)'(1);
    if (nar_i)           posit_o = {1'b1, {(N-1){1'b0}}};
    else if (mag == '0)  posit_o = '0;
    else if (neg)        posit_o = -{1'b0, body};
    else                 posit_o = {1'b0, body};
  end

endmodule

// File: rtl/posit_mac.sv
module posit_mac
  import posit_mac_pkg::*;
#(
  parameter int N  = 8,
  parameter int ES = 1,
  parameter int GB = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         clear_i,
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic         valid_o,
  output logic [N-1:0] result_o
);

  localparam int SCW = scale_width(N, ES);
  localparam int FB  = frac_bits(N, ES);
  localparam int AW  = acc_width(N, ES, GB);

  logic [N-1:0]          op [2];
  pclass_e               d_cls [2];
  logic                  d_sign [2];
  logic signed [SCW-1:0] d_scale [2];
  logic [FB:0]           d_sig [2];

  pclass_e               s1_cls [2];
  logic                  s1_sign [2];
  logic signed [SCW-1:0] s1_scale [2];
  logic [FB:0]           s1_sig [2];
  logic                  s1_valid;
  logic                  s1_clear;

  logic                  s2_valid;
  logic                  s2_nar;
  logic signed [AW-1:0]  s2_acc;
  logic [N-1:0]          enc;

  assign op[0] = a_i;
  assign op[1] = b_i;

  for (genvar g = 0; g < 2; g++) begin : g_dec
    posit_decoder #(.N(N), .ES(ES), .SCW(SCW), .FB(FB)) u_dec (
      .p_i    (op[g]),
      .cls_o  (d_cls[g]),
      .sign_o (d_sign[g]),
      .scale_o(d_scale[g]),
      .sig_o  (d_sig[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_clear <= 1'b0;
      for (int i = 0; i < 2; i++) begin
        s1_cls[i]   <= PC_ZERO;
        s1_sign[i]  <= 1'b0;
        s1_scale[i] <= '0;
        s1_sig[i]   <= '0;
      end
    end else begin
      s1_valid <= valid_i;
      s1_clear <= clear_i;
      for (int i = 0; i < 2; i++) begin
        s1_cls[i]   <= d_cls[i];
        s1_sign[i]  <= d_sign[i];
        s1_scale[i] <= d_scale[i];
        s1_sig[i]   <= d_sig[i];
      end
    end
  end

  posit_mac_core #(.N(N), .ES(ES), .GB(GB), .SCW(SCW), .FB(FB), .AW(AW)) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (s1_valid),
    .clear_i  (s1_clear),
    .cls_a_i  (s1_cls[0]),
    .sign_a_i (s1_sign[0]),
    .scale_a_i(s1_scale[0]),
    .sig_a_i  (s1_sig[0]),
    .cls_b_i  (s1_cls[1]),
    .sign_b_i (s1_sign[1]),
    .scale_b_i(s1_scale[1]),
    .sig_b_i  (s1_sig[1]),
    .valid_o  (s2_valid),
    .nar_o    (s2_nar),
    .acc_o    (s2_acc)
  );

  posit_encoder #(.N(N), .ES(ES), .AW(AW)) u_enc (
    .acc_i  (s2_acc),
    .nar_i  (s2_nar),
    .posit_o(enc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= s2_valid;
      if (s2_valid) result_o <= enc;
    end
  end

endmodule

// File: rtl/posit_mac_chk.sv
module posit_mac_chk #(
  parameter int N  = 8,
  parameter int ES = 1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         clear_i,
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic         valid_o,
  input logic [N-1:0] result_o
);

  localparam logic [N-1:0] NAR  = {1'b1, {(N-1){1'b0}}};
  localparam logic [N-1:0] MAXP = {1'b0, {(N-1){1'b1}}};
  localparam logic [N-1:0] MINP = N'(1);

  a_r1_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i, 3));

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o));

  a_r8_nar: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_i && (a_i == NAR || b_i == NAR), 3)) |-> result_o == NAR);

  a_r7_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_i && clear_i && (a_i == '0 || b_i == '0)
                      && a_i != NAR && b_i != NAR, 3)) |-> result_o == '0);

  a_r6_sat_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_i && clear_i && a_i == MAXP && b_i == MAXP, 3))
      |-> result_o == MAXP);

  a_r6_sat_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_i && clear_i && a_i == MINP && b_i == MINP, 3))
      |-> result_o == MINP);

endmodule

bind posit_mac posit_mac_chk #(.N(N), .ES(ES)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .clear_i (clear_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .valid_o (valid_o),
  .result_o(result_o)
);

// File: tb/posit_mac_tb_top.sv
module posit_mac_tb_top;

  localparam int N  = 8;
  localparam int ES = 1;
  localparam int SM = (N - 2) << ES;
  localparam int CW = 2 ** N;
  localparam int NARC = 2 ** (N - 1);

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic         clear = 1'b0;
  logic [N-1:0] a = '0;
  logic [N-1:0] b = '0;
  logic         valid_o;
  logic [N-1:0] result_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  posit_mac #(.N(N), .ES(ES)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .clear_i(clear),
    .a_i(a), .b_i(b), .valid_o(valid_o), .result_o(result_o)
  );

  // value of each code, in units of 2^-SM (R2)
  longint vtab [CW];

  function automatic longint pval(int code);
    int m, r0, run, i, e, f, nf, k, sc;
    if (code == 0 || code == NARC) return 0;
    m = (code >= NARC) ? (CW - code) : code;
    r0 = (m >> (N - 2)) & 1;
    run = 0;
    i = N - 2;
    while (i >= 0 && ((m >> i) & 1) == r0) begin run++; i--; end
    i--;
    e = 0;
    for (int j = 0; j < ES; j++) begin
      e = e * 2 + ((i >= 0) ? ((m >> i) & 1) : 0);
      i--;
    end
    f = 0; nf = 0;
    while (i >= 0) begin f = f * 2 + ((m >> i) & 1); nf++; i--; end
    k  = (r0 == 1) ? run - 1 : -run;
    sc = k * (2 ** ES) + e;
    pval = ((longint'(1 << nf) + f) <<< (sc + SM)) >>> nf;
    if (code >= NARC) pval = -pval;
  endfunction

  // R5/R6/R7/R8: expected code for a sum in units of 2^-2SM
  function automatic int exp_code(longint s, bit nar);
    longint mg;
    int best;
    if (nar) return NARC;
    if (s == 0) return 0;
    mg = (s < 0) ? -s : s;
    best = 1;
    for (int c = 1; c < NARC; c++)
      if ((vtab[c] <<< SM) <= mg) best = c;
    return (s < 0) ? (CW - best) : best;
  endfunction

  typedef struct { int code; int cyc; string tag; } item_t;
  item_t  sb [$];
  longint acc_m = 0;
  bit     nar_m = 1'b0;

  task automatic chk(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic issue(int x, int y, bit clr, string tag);
    longint p;
    bit     n;
    item_t  it;
    @(negedge clk);
    valid = 1'b1; clear = clr; a = N'(x); b = N'(y);
    n = (x == NARC) || (y == NARC);
    p = n ? 0 : vtab[x] * vtab[y];
    if (clr) begin acc_m = p; nar_m = n; end
    else begin acc_m += p; nar_m |= n; end
    it.code = exp_code(acc_m, nar_m);
    it.cyc  = cyc;
    it.tag  = tag;
    sb.push_back(it);
  endtask

  task automatic idle(int n, bit clr, int x);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0; clear = clr; a = N'(x); b = N'(x);
    end
  endtask

  // monitor: compares results as they appear; R1 timing, R9 hold
  logic [N-1:0] last_res = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o) begin
        if (sb.size() == 0) chk(1'b0, "R1 unexpected valid_o", 1, 0);
        else begin
          item_t it;
          it = sb.pop_front();
          chk(result_o == N'(it.code), it.tag, int'(result_o), it.code);
          chk(cyc == it.cyc + 3, "R1 latency", cyc - it.cyc, 3);
        end
      end else begin
        chk(result_o == last_res, "R9 hold", int'(result_o), int'(last_res));
      end
      last_res = result_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < CW; c++) vtab[c] = pval(c);
    repeat (3) @(negedge clk);
    chk(valid_o == 1'b0, "R10 valid_o in reset", int'(valid_o), 0);
    chk(result_o == '0, "R10 result_o in reset", int'(result_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2, 1'b0, 0);

    // R3 / R4 basics
    issue(8'h40, 8'h40, 1'b1, "R3 clear 1*1");
    issue(8'h50, 8'h40, 1'b0, "R4 add 2*1");
    issue(8'h48, 8'h48, 1'b0, "R4 add 1.5*1.5");
    // R5 truncation, both signs
    issue(8'h4F, 8'h4F, 1'b1, "R5 truncate positive");
    issue(8'hB1, 8'h4F, 1'b1, "R5 truncate negative");
    issue(8'h5B, 8'h67, 1'b1, "R5 truncate mid range");
    // R6 clamps
    issue(8'h7F, 8'h7F, 1'b1, "R6 maxpos squared");
    issue(8'h81, 8'h7F, 1'b1, "R6 negative clamp high");
    issue(8'h01, 8'h01, 1'b1, "R6 minpos squared");
    issue(8'hFF, 8'h01, 1'b1, "R6 negative clamp low");
    // R7 zero
    issue(8'h00, 8'h7F, 1'b1, "R7 zero operand");
    issue(8'h40, 8'h40, 1'b0, "R7 add after zero");
    issue(8'h50, 8'h40, 1'b1, "R7 cancel start");
    issue(8'hB0, 8'h40, 1'b0, "R7 cancel to zero");
    // R8 sticky NaR
    issue(8'h40, 8'h40, 1'b1, "R8 before NaR");
    issue(8'h80, 8'h40, 1'b0, "R8 NaR operand");
    issue(8'h40, 8'h40, 1'b0, "R8 NaR sticky");
    idle(2, 1'b0, 0);
    issue(8'h00, 8'h80, 1'b0, "R8 NaR times zero");
    issue(8'h40, 8'h50, 1'b1, "R8 cleared");
    // R9 idle cycles with clear high must not restart the sum
    issue(8'h40, 8'h40, 1'b1, "R9 start");
    idle(3, 1'b1, 8'h7F);
    issue(8'h40, 8'h40, 1'b0, "R9 clear ignored without valid");
    idle(4, 1'b0, 0);

    // R2: every real code times one reproduces itself
    for (int c = 1; c < CW; c++) begin
      if (c != NARC) issue(c, 8'h40, 1'b1, "R2 decode/encode identity");
    end
    idle(3, 1'b0, 0);

    // R4/R5 random streams with gaps
    for (int i = 0; i < 500; i++) begin
      int x, y;
      bit cl;
      x = $urandom_range(0, CW - 1);
      y = $urandom_range(0, CW - 1);
      if (x == NARC) x = 8'h40;
      if (y == NARC) y = 8'h3C;
      cl = (i % 12 == 0) || ($urandom_range(0, 9) == 0);
      issue(x, y, cl, "R4 random stream");
      if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3), 1'b1, 8'h7F);
    end
    idle(8, 1'b0, 0);
    chk(sb.size() == 0, "R1 all results returned", sb.size(), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule